// File: doc/BRIEF.md
# Tile Video Processor Register Interface

This block is the processor-facing register file of a tile-based video processor. A host reaches eight byte-wide registers through a 3-bit register select, a write strobe and a read strobe. The block holds the control, mask and status bytes, the object memory pointer, the 15-bit current and temporary scroll addresses, the 3-bit fine horizontal scroll and one first/second write toggle. The scroll and address registers share that toggle.

A data port gives access to three regions, chosen by the current address. Pattern memory is read through a one-byte buffer, so each read returns the byte fetched by the previous pattern read. Name-table RAM is external, holds 2 KB and is reached through a selectable mirroring map. The 32-entry palette is internal and its sprite backdrop slots alias onto the background slots. Every data-port access steps the current address by 1 or by 32. The rendering logic reads the scroll state and the control and mask bytes from output ports. The rendering logic also raises and clears the status flags through event inputs.

Top module: `vid_regif`

## Requirements
- R1: An active-low asynchronous reset clears control, mask, status, both scroll addresses, fine X, the object pointer, the read buffer, the palette and the write toggle.
- R2: The register select codes are: 0 control (write), 1 mask (write), 2 status (read), 3 object pointer (write), 4 object data (read/write), 5 scroll (write), 6 address (write), 7 data port (read/write). A control write loads the control byte and copies data bits 1:0 into temporary bits 11:10. A mask write loads the mask byte.
- R3: A scroll write with the toggle clear loads fine X from data bits 2:0 and temporary bits 4:0 from data bits 7:3. A scroll write with the toggle set loads temporary bits 14:12 from data bits 2:0 and bits 9:5 from data bits 7:3. Each scroll write inverts the toggle.
- R4: An address write with the toggle clear loads temporary bits 13:8 from data bits 5:0 and clears temporary bit 14. An address write with the toggle set loads temporary bits 7:0 and then copies the whole temporary address into the current address. Each address write inverts the toggle.
- R5: Scroll writes and address writes use the same toggle. A status read returns {flag7, flag6, flag5, 5'b0}. After the read, the toggle is zero and status bit 7 is clear.
- R6: Input stat_set_i[2:0] sets status bits 7:5 and input stat_clr_i[2:0] clears them. When a set, a clear or a status read fall in the same cycle, the set wins.
- R7: An object-pointer write loads the pointer. An object-data write stores the byte at the pointer through the object memory port and then increments the pointer, wrapping at 8 bits. An object-data read returns obj_rdata_i and leaves the pointer unchanged.
- R8: Every data-port read or write adds 32 to the 15-bit current address when control bit 2 is set, and adds 1 when it is clear. The address wraps at 15 bits. Region decode uses current-address bits 13:0.
- R9: Current addresses below 0x2000 select the pattern region. A data-port read there returns the buffered byte and loads the buffer with pat_rdata_i from address bits 12:0. A data-port write there touches no memory.
- R10: Current addresses from 0x2000 to 0x3EFF select the name-table region, which is read and written directly. The name-table index is {a[11], a[9:0]} when mirror_i is 0 and {a[10], a[9:0]} when mirror_i is 1.
- R11: Current addresses with bits 13:8 equal to 0x3F select the palette, which is read and written directly. The palette index is a[4:0]. Indices 0x10, 0x14, 0x18 and 0x1C map to 0x00, 0x04, 0x08 and 0x0C.
- R12: When both strobes are high in one cycle, only the write takes effect. The read side effects do not happen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 3 | Register select |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the selected register (combinational) |
| mirror_i | input | 1 | Name-table mirroring: 0 uses a[11], 1 uses a[10] |
| stat_set_i | input | 3 | Set status bits 7:5 |
| stat_clr_i | input | 3 | Clear status bits 7:5 |
| ctrl_o | output | 8 | Control byte |
| mask_o | output | 8 | Mask byte |
| t_addr_o | output | 15 | Temporary scroll address |
| v_addr_o | output | 15 | Current scroll address |
| fine_x_o | output | 3 | Fine horizontal scroll |
| obj_addr_o | output | 8 | Object memory pointer |
| obj_we_o | output | 1 | Object memory write enable |
| obj_wdata_o | output | 8 | Object memory write data |
| obj_rdata_i | input | 8 | Object memory read data at obj_addr_o |
| nt_addr_o | output | 11 | Name-table RAM index |
| nt_we_o | output | 1 | Name-table RAM write enable |
| nt_wdata_o | output | 8 | Name-table RAM write data |
| nt_rdata_i | input | 8 | Name-table RAM read data at nt_addr_o |
| pat_addr_o | output | 13 | Pattern memory address |
| pat_rd_o | output | 1 | Pattern memory read strobe |
| pat_rdata_i | input | 8 | Pattern memory read data at pat_addr_o |

## Verification
The bench interleaves scroll writes, address writes and status reads so that the shared toggle crosses from one register to the other. A design with two toggles, or one that a status read does not reset, would then send the low address byte into the high half and load the wrong current address. It reads pattern memory at consecutive addresses and puts an ignored pattern write in between. A buffer that refills at the wrong time, or a read that bypasses the buffer, returns data one read early or one read late. It writes and reads the palette alias slots, the name-table mirrors under both mirroring settings, an increment from 0x3FFF into bit 14, the object pointer wrapping from 0xFF, and cycles where a flag set meets a status read. Each of these has a wrong version that shows up as a mismatched read byte or a wrong register value on that same clock.

// File: rtl/vid_regif_pkg.sv
package vid_regif_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned AW = 15;

  typedef enum logic [2:0] {
    SEL_CTRL = 3'd0,
    SEL_MASK = 3'd1,
    SEL_STAT = 3'd2,
    SEL_OADR = 3'd3,
    SEL_ODAT = 3'd4,
    SEL_SCRL = 3'd5,
    SEL_ADDR = 3'd6,
    SEL_DATA = 3'd7
  } reg_sel_e;

  typedef enum logic [1:0] {
    RGN_PAT = 2'd0,
    RGN_NT  = 2'd1,
    RGN_PAL = 2'd2
  } region_e;
endpackage

// File: rtl/vid_scroll_unit.sv
module vid_scroll_unit #(
  parameter int unsigned AW = 15,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] wdata_i,
  input  logic          ctrl_wr_i,
  input  logic          scrl_wr_i,
  input  logic          addr_wr_i,
  input  logic          stat_rd_i,
  input  logic          port_acc_i,
  input  logic          inc32_i,
  output logic [AW-1:0] t_o,
  output logic [AW-1:0] v_o,
  output logic [2:0]    fx_o,
  output logic          tog_o
);
  localparam logic [AW-1:0] STEP_ROW = AW'(32);
  localparam logic [AW-1:0] STEP_ONE = AW'(1);

  logic [AW-1:0] t_q, v_q;
  logic [2:0]    fx_q;
  logic          tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t_q   <= '0;
      v_q   <= '0;
      fx_q  <= '0;
      tog_q <= 1'b0;
    end else begin
      if (ctrl_wr_i) t_q[11:10] <= wdata_i[1:0];
      if (scrl_wr_i) begin
        if (!tog_q) begin
          fx_q     <= wdata_i[2:0];
          t_q[4:0] <= wdata_i[7:3];
        end else begin
          t_q[14:12] <= wdata_i[2:0];
          t_q[9:5]   <= wdata_i[7:3];
        end
        tog_q <= ~tog_q;
      end
      if (addr_wr_i) begin
        if (!tog_q) begin
          t_q[13:8] <= wdata_i[5:0];
          t_q[14]   <= 1'b0;
        end else begin
          t_q[7:0] <= wdata_i;
          v_q      <= {t_q[AW-1:8], wdata_i};
        end
        tog_q <= ~tog_q;
      end
      if (stat_rd_i) tog_q <= 1'b0;
      if (port_acc_i) v_q <= v_q + (inc32_i ? STEP_ROW : STEP_ONE);
    end
  end

  assign t_o   = t_q;
  assign v_o   = v_q;
  assign fx_o  = fx_q;
  assign tog_o = tog_q;
endmodule

// File: rtl/vid_port_map.sv
module vid_port_map
  import vid_regif_pkg::*;
#(
  parameter int unsigned NT_AW  = 11,
  parameter int unsigned PAT_AW = 13,
  parameter int unsigned PAL_IW = 5
) (
  input  logic [13:0]       a_i,
  input  logic              mirror_i,
  output region_e           region_o,
  output logic [NT_AW-1:0]  nt_idx_o,
  output logic [PAT_AW-1:0] pat_addr_o,
  output logic [PAL_IW-1:0] pal_idx_o
);
  localparam logic [5:0] PAL_PAGE = 6'h3F;

  always_comb begin
    if (!a_i[13])                 region_o = RGN_PAT;
    else if (a_i[13:8] == PAL_PAGE) region_o = RGN_PAL;
    else                          region_o = RGN_NT;
  end

  // mirror_i picks which nametable select bit survives
  assign nt_idx_o   = mirror_i ? {a_i[10], a_i[9:0]} : {a_i[11], a_i[9:0]};
  assign pat_addr_o = a_i[PAT_AW-1:0];
  assign pal_idx_o  = a_i[PAL_IW-1:0];
endmodule

// File: rtl/vid_palette.sv
module vid_palette #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [$clog2(DEPTH)-1:0] idx_i,
  input  logic [DW-1:0]            wdata_i,
  output logic [DW-1:0]            rdata_o
);
  localparam int unsigned IW = $clog2(DEPTH);

  logic [IW-1:0] eff_idx;
  logic [DW-1:0] ent_q [DEPTH];

  // sprite backdrop slots share storage with background slots
  always_comb begin
    eff_idx = idx_i;
    if (idx_i[IW-1] && (idx_i[1:0] == 2'b00)) eff_idx[IW-1] = 1'b0;
  end

  for (genvar k = 0; k < DEPTH; k++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                ent_q[k] <= '0;
      else if (we_i && (eff_idx == IW'(k)))       ent_q[k] <= wdata_i;
    end
  end

  assign rdata_o = ent_q[eff_idx];
endmodule

// File: rtl/vid_regif.sv
module vid_regif
  import vid_regif_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    sel_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o,
  input  logic          mirror_i,
  input  logic [2:0]    stat_set_i,
  input  logic [2:0]    stat_clr_i,
  output logic [7:0]    ctrl_o,
  output logic [7:0]    mask_o,
  output logic [14:0]   t_addr_o,
  output logic [14:0]   v_addr_o,
  output logic [2:0]    fine_x_o,
  output logic [7:0]    obj_addr_o,
  output logic          obj_we_o,
  output logic [7:0]    obj_wdata_o,
  input  logic [7:0]    obj_rdata_i,
  output logic [10:0]   nt_addr_o,
  output logic          nt_we_o,
  output logic [7:0]    nt_wdata_o,
  input  logic [7:0]    nt_rdata_i,
  output logic [12:0]   pat_addr_o,
  output logic          pat_rd_o,
  input  logic [7:0]    pat_rdata_i
);
  localparam int unsigned NREG    = 8;
  localparam int unsigned PAL_DEP = 32;
  localparam int unsigned PAL_IW  = $clog2(PAL_DEP);
  localparam int unsigned NSTAT   = 3;

  logic [NREG-1:0] wr_dec, rd_dec;
  logic            rd_en;

  // write strobe has priority
  assign rd_en = rd_i & ~wr_i;

  for (genvar k = 0; k < NREG; k++) begin : g_dec
    assign wr_dec[k] = wr_i  && (sel_i == 3'(k));
    assign rd_dec[k] = rd_en && (sel_i == 3'(k));
  end

  logic [DW-1:0]    ctrl_q, mask_q, oadr_q, rbuf_q;
  logic [NSTAT-1:0] stat_q;
  logic [AW-1:0]    t_w, v_w;
  logic             tog;
  region_e          region;
  logic [PAL_IW-1:0] pal_idx;
  logic [DW-1:0]    pal_rdata;
  logic             port_acc;

  assign port_acc = wr_dec[SEL_DATA] | rd_dec[SEL_DATA];

  vid_scroll_unit #(.AW(AW), .DW(DW)) u_scroll (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wdata_i    (wdata_i),
    .ctrl_wr_i  (wr_dec[SEL_CTRL]),
    .scrl_wr_i  (wr_dec[SEL_SCRL]),
    .addr_wr_i  (wr_dec[SEL_ADDR]),
    .stat_rd_i  (rd_dec[SEL_STAT]),
    .port_acc_i (port_acc),
    .inc32_i    (ctrl_q[2]),
    .t_o        (t_w),
    .v_o        (v_w),
    .fx_o       (fine_x_o),
    .tog_o      (tog)
  );

  vid_port_map #(.NT_AW(11), .PAT_AW(13), .PAL_IW(PAL_IW)) u_map (
    .a_i        (v_w[13:0]),
    .mirror_i   (mirror_i),
    .region_o   (region),
    .nt_idx_o   (nt_addr_o),
    .pat_addr_o (pat_addr_o),
    .pal_idx_o  (pal_idx)
  );

  vid_palette #(.DW(DW), .DEPTH(PAL_DEP)) u_pal (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_dec[SEL_DATA] && (region == RGN_PAL)),
    .idx_i   (pal_idx),
    .wdata_i (wdata_i),
    .rdata_o (pal_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      mask_q <= '0;
      oadr_q <= '0;
      rbuf_q <= '0;
      stat_q <= '0;
    end else begin
      if (wr_dec[SEL_CTRL]) ctrl_q <= wdata_i;
      if (wr_dec[SEL_MASK]) mask_q <= wdata_i;
      if (wr_dec[SEL_OADR]) oadr_q <= wdata_i;
      else if (wr_dec[SEL_ODAT]) oadr_q <= oadr_q + 8'd1;
      if (rd_dec[SEL_DATA] && (region == RGN_PAT)) rbuf_q <= pat_rdata_i;
      // event set beats clear and read-clear
      stat_q <= stat_set_i |
                (stat_q & ~stat_clr_i & ~{rd_dec[SEL_STAT], {(NSTAT-1){1'b0}}});
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (sel_i)
      SEL_STAT: rdata_o = {stat_q, {(DW-NSTAT){1'b0}}};
      SEL_ODAT: rdata_o = obj_rdata_i;
      SEL_DATA: begin
        unique case (region)
          RGN_PAT: rdata_o = rbuf_q;
          RGN_NT:  rdata_o = nt_rdata_i;
          RGN_PAL: rdata_o = pal_rdata;
          default: rdata_o = '0;
        endcase
      end
      default:  rdata_o = '0;
    endcase
  end

  assign ctrl_o      = ctrl_q;
  assign mask_o      = mask_q;
  assign t_addr_o    = t_w;
  assign v_addr_o    = v_w;
  assign obj_addr_o  = oadr_q;
  assign obj_we_o    = wr_dec[SEL_ODAT];
  assign obj_wdata_o = wdata_i;
  assign nt_we_o     = wr_dec[SEL_DATA] && (region == RGN_NT);
  assign nt_wdata_o  = wdata_i;
  assign pat_rd_o    = rd_dec[SEL_DATA] && (region == RGN_PAT);
endmodule

// File: rtl/vid_regif_chk.sv
module vid_regif_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [2:0]  sel_i,
  input logic        wr_i,
  input logic        rd_i,
  input logic [7:0]  wdata_i,
  input logic [2:0]  stat_set_i,
  input logic [7:0]  ctrl_o,
  input logic [14:0] t_addr_o,
  input logic [14:0] v_addr_o,
  input logic [7:0]  obj_addr_o,
  input logic        nt_we_o,
  input logic        pat_rd_o,
  input logic        tog,
  input logic        stat7
);
  // R2
  ctrl_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i == 3'd0) |=> (ctrl_o == $past(wdata_i) && t_addr_o[11:10] == $past(wdata_i[1:0])));

  // R4
  addr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i == 3'd6 && tog) |=> (v_addr_o == t_addr_o));

  // R5
  stat_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && sel_i == 3'd2 && !stat_set_i[2]) |=> (!stat7 && !tog));

  // R6
  stat_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_set_i[2] |=> stat7);

  // R7
  obj_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i == 3'd4) |=> (obj_addr_o == $past(obj_addr_o) + 8'd1));

  // R7
  obj_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && sel_i == 3'd4) |=> $stable(obj_addr_o));

  // R8
  port_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wr_i || rd_i) && sel_i == 3'd7) |=>
      (v_addr_o == $past(v_addr_o) + ($past(ctrl_o[2]) ? 15'd32 : 15'd1)));

  // R9
  port_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({nt_we_o, pat_rd_o}));

  // R12
  wr_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && rd_i) |-> !pat_rd_o);
endmodule

bind vid_regif vid_regif_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sel_i      (sel_i),
  .wr_i       (wr_i),
  .rd_i       (rd_i),
  .wdata_i    (wdata_i),
  .stat_set_i (stat_set_i),
  .ctrl_o     (ctrl_o),
  .t_addr_o   (t_addr_o),
  .v_addr_o   (v_addr_o),
  .obj_addr_o (obj_addr_o),
  .nt_we_o    (nt_we_o),
  .pat_rd_o   (pat_rd_o),
  .tog        (tog),
  .stat7      (stat_q[2])
);

// File: tb/vid_regif_test.sv
`timescale 1ns/1ps
module vid_regif_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [2:0]  sel = '0;
  logic        wr = 1'b0, rd = 1'b0, mirror = 1'b0;
  logic [7:0]  wdata = '0;
  logic [2:0]  sset = '0, sclr = '0;
  logic [7:0]  rdata, ctrl, mask, oadr, owdata, nwdata;
  logic [14:0] t_addr, v_addr;
  logic [2:0]  fx;
  logic        owe, nwe, prd;
  logic [10:0] naddr;
  logic [12:0] paddr;
  logic [7:0]  ordata, nrdata, prdata;

  logic [7:0] ext_obj [256];
  logic [7:0] ext_nt  [2048];

  function automatic logic [7:0] patfn(input logic [12:0] a);
    return a[7:0] ^ {a[12:8], 3'b101};
  endfunction

  always @(posedge clk) begin
    if (owe) ext_obj[oadr] <= owdata;
    if (nwe) ext_nt[naddr] <= nwdata;
  end
  assign ordata = ext_obj[oadr];
  assign nrdata = ext_nt[naddr];
  assign prdata = patfn(paddr);

  vid_regif uut (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .mirror_i(mirror),
    .stat_set_i(sset), .stat_clr_i(sclr), .ctrl_o(ctrl), .mask_o(mask),
    .t_addr_o(t_addr), .v_addr_o(v_addr), .fine_x_o(fx), .obj_addr_o(oadr),
    .obj_we_o(owe), .obj_wdata_o(owdata), .obj_rdata_i(ordata),
    .nt_addr_o(naddr), .nt_we_o(nwe), .nt_wdata_o(nwdata), .nt_rdata_i(nrdata),
    .pat_addr_o(paddr), .pat_rd_o(prd), .pat_rdata_i(prdata)
  );

  // reference model state
  logic [7:0]  m_ctrl = 0, m_mask = 0, m_oadr = 0, m_buf = 0;
  logic [2:0]  m_stat = 0, m_fx = 0;
  logic [14:0] m_t = 0, m_v = 0;
  logic        m_tog = 0;
  logic [7:0]  m_obj [256];
  logic [7:0]  m_nt  [2048];
  logic [7:0]  m_pal [32];

  int n_chk = 0, n_bad = 0;
  bit cmp_en = 0, done = 0;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int region(input logic [13:0] a);
    if (!a[13]) return 0;
    if (a[13:8] == 6'h3F) return 2;
    return 1;
  endfunction

  function automatic logic [10:0] ntmap(input logic [13:0] a);
    return mirror ? {a[10], a[9:0]} : {a[11], a[9:0]};
  endfunction

  function automatic logic [4:0] palmap(input logic [13:0] a);
    logic [4:0] i = a[4:0];
    if (i == 5'h10 || i == 5'h14 || i == 5'h18 || i == 5'h1C) i = i - 5'h10;
    return i;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [2:0] s);
    logic [13:0] a = m_v[13:0];
    case (s)
      3'd2: return {m_stat, 5'b0};
      3'd4: return m_obj[m_oadr];
      3'd7: begin
        case (region(a))
          0: return m_buf;
          1: return m_nt[ntmap(a)];
          default: return m_pal[palmap(a)];
        endcase
      end
      default: return 8'h00;
    endcase
  endfunction

  // per-clock comparison of every visible register
  always @(negedge clk) begin
    if (cmp_en && !done) begin
      chk("R2 ctrl", {8'h0, ctrl}, {8'h0, m_ctrl});
      chk("R2 mask", {8'h0, mask}, {8'h0, m_mask});
      chk("R3 t_addr", {1'b0, t_addr}, {1'b0, m_t});
      chk("R3 fine_x", {13'h0, fx}, {13'h0, m_fx});
      chk("R8 v_addr", {1'b0, v_addr}, {1'b0, m_v});
      chk("R7 obj_addr", {8'h0, oadr}, {8'h0, m_oadr});
    end
  end

  task automatic acc(input logic w, input logic r, input logic [2:0] s, input logic [7:0] d,
                     input logic [2:0] set, input logic [2:0] clr, input string tag);
    logic [13:0] a;
    int rg;
    logic rdclr;
    @(negedge clk);
    sel = s; wr = w; rd = r; wdata = d; sset = set; sclr = clr;
    #1;
    a = m_v[13:0];
    rg = region(a);
    rdclr = 1'b0;
    if (s == 3'd7 && (w || r)) begin
      chk({tag, " nt_we"}, {15'h0, nwe}, {15'h0, (w && rg == 1)});
      chk({tag, " pat_rd"}, {15'h0, prd}, {15'h0, (r && !w && rg == 0)});
    end
    if (r && !w) chk({tag, " rdata"}, {8'h0, rdata}, {8'h0, exp_rd(s)});
    @(posedge clk);
    #1;
    if (w) begin
      case (s)
        3'd0: begin m_ctrl = d; m_t[11:10] = d[1:0]; end
        3'd1: m_mask = d;
        3'd3: m_oadr = d;
        3'd4: begin m_obj[m_oadr] = d; m_oadr = m_oadr + 8'd1; end
        3'd5: begin
          if (!m_tog) begin m_fx = d[2:0]; m_t[4:0] = d[7:3]; end
          else begin m_t[14:12] = d[2:0]; m_t[9:5] = d[7:3]; end
          m_tog = ~m_tog;
        end
        3'd6: begin
          if (!m_tog) begin m_t[13:8] = d[5:0]; m_t[14] = 1'b0; end
          else begin m_t[7:0] = d; m_v = m_t; end
          m_tog = ~m_tog;
        end
        3'd7: begin
          if (rg == 1) m_nt[ntmap(a)] = d;
          else if (rg == 2) m_pal[palmap(a)] = d;
          m_v = m_v + (m_ctrl[2] ? 15'd32 : 15'd1);
        end
        default: ;
      endcase
    end else if (r) begin
      if (s == 3'd2) begin rdclr = 1'b1; m_tog = 1'b0; end
      if (s == 3'd7) begin
        if (rg == 0) m_buf = patfn(a[12:0]);
        m_v = m_v + (m_ctrl[2] ? 15'd32 : 15'd1);
      end
    end
    m_stat = set | (m_stat & ~clr & ~{rdclr, 2'b00});
    wr = 0; rd = 0; sset = 0; sclr = 0;
  endtask

  task automatic wreg(input logic [2:0] s, input logic [7:0] d, input string tag);
    acc(1'b1, 1'b0, s, d, 3'b0, 3'b0, tag);
  endtask
  task automatic rreg(input logic [2:0] s, input string tag);
    acc(1'b0, 1'b1, s, 8'h00, 3'b0, 3'b0, tag);
  endtask
  // assumes toggle clear
  task automatic setv(input logic [13:0] a, input string tag);
    wreg(3'd6, {2'b00, a[13:8]}, tag);
    wreg(3'd6, a[7:0], tag);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin ext_obj[i] = 0; m_obj[i] = 0; end
    for (int i = 0; i < 2048; i++) begin ext_nt[i] = 0; m_nt[i] = 0; end
    for (int i = 0; i < 32; i++) m_pal[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cmp_en = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 v_addr", {1'b0, v_addr}, 16'h0);
    chk("R1 t_addr", {1'b0, t_addr}, 16'h0);
    rreg(3'd2, "R1");
    rreg(3'd7, "R1");
    // R2
    wreg(3'd0, 8'hA7, "R2");
    chk("R2 t_addr", {1'b0, t_addr}, 16'h0C00);
    wreg(3'd1, 8'h1E, "R2");
    // R3
    wreg(3'd5, 8'h7D, "R3");
    chk("R3 fine_x", {13'h0, fx}, 16'h5);
    wreg(3'd5, 8'h5E, "R3");
    chk("R3 t_addr", {1'b0, t_addr}, 16'h6D6F);
    // R4
    wreg(3'd6, 8'hFF, "R4");
    chk("R4 t_addr", {1'b0, t_addr}, 16'h3F6F);
    wreg(3'd6, 8'h12, "R4");
    chk("R4 v_addr", {1'b0, v_addr}, 16'h3F12);
    // R5 shared toggle
    wreg(3'd5, 8'h08, "R5");
    wreg(3'd6, 8'h21, "R5");
    chk("R5 v_addr", {1'b0, v_addr}, 16'h3F21);
    wreg(3'd5, 8'h00, "R5");
    rreg(3'd2, "R5");
    wreg(3'd6, 8'h15, "R5");
    chk("R5 t_addr", {1'b0, t_addr}, 16'h1520);
    chk("R5 v_addr", {1'b0, v_addr}, 16'h3F21);
    wreg(3'd6, 8'h00, "R5");
    // R6 status events
    acc(1'b0, 1'b0, 3'd0, 8'h00, 3'b100, 3'b000, "R6");
    acc(1'b0, 1'b1, 3'd2, 8'h00, 3'b100, 3'b000, "R6");
    rreg(3'd2, "R6");
    rreg(3'd2, "R5");
    acc(1'b0, 1'b0, 3'd0, 8'h00, 3'b011, 3'b000, "R6");
    rreg(3'd2, "R6");
    acc(1'b0, 1'b0, 3'd0, 8'h00, 3'b001, 3'b011, "R6");
    rreg(3'd2, "R6");
    // R7 object memory
    wreg(3'd3, 8'hFE, "R7");
    wreg(3'd4, 8'h10, "R7");
    wreg(3'd4, 8'h20, "R7");
    wreg(3'd4, 8'h30, "R7");
    chk("R7 obj_addr", {8'h0, oadr}, 16'h0001);
    rreg(3'd4, "R7");
    rreg(3'd4, "R7");
    chk("R7 obj_addr", {8'h0, oadr}, 16'h0001);
    wreg(3'd3, 8'hFF, "R7");
    rreg(3'd4, "R7");
    // R12 both strobes
    acc(1'b1, 1'b1, 3'd4, 8'h77, 3'b0, 3'b0, "R12");
    chk("R12 obj_addr", {8'h0, oadr}, 16'h0000);
    wreg(3'd3, 8'hFF, "R12");
    rreg(3'd4, "R12");
    // R8 increments
    wreg(3'd0, 8'h04, "R8");
    setv(14'h2000, "R8");
    wreg(3'd7, 8'h11, "R8");
    rreg(3'd7, "R8");
    chk("R8 v_addr", {1'b0, v_addr}, 16'h2040);
    wreg(3'd0, 8'h00, "R8");
    setv(14'h3FFF, "R8");
    wreg(3'd7, 8'h5A, "R8");
    chk("R8 v_addr", {1'b0, v_addr}, 16'h4000);
    rreg(3'd7, "R8");
    // R9 buffered pattern reads
    setv(14'h0123, "R9");
    rreg(3'd7, "R9");
    rreg(3'd7, "R9");
    wreg(3'd7, 8'h55, "R9");
    rreg(3'd7, "R9");
    rreg(3'd7, "R9");
    // R10 mirroring
    mirror = 1'b0;
    setv(14'h2005, "R10");
    wreg(3'd7, 8'hA1, "R10");
    setv(14'h2405, "R10");
    rreg(3'd7, "R10");
    setv(14'h2805, "R10");
    wreg(3'd7, 8'hB2, "R10");
    mirror = 1'b1;
    setv(14'h2405, "R10");
    rreg(3'd7, "R10");
    setv(14'h2C05, "R10");
    rreg(3'd7, "R10");
    setv(14'h3805, "R10");
    rreg(3'd7, "R10");
    // R11 palette aliasing
    setv(14'h3F10, "R11");
    wreg(3'd7, 8'h2A, "R11");
    wreg(3'd7, 8'h33, "R11");
    setv(14'h3F00, "R11");
    rreg(3'd7, "R11");
    rreg(3'd7, "R11");
    setv(14'h3FEC, "R11");
    wreg(3'd7, 8'h44, "R11");
    setv(14'h3F1C, "R11");
    rreg(3'd7, "R11");
    setv(14'h3F11, "R11");
    rreg(3'd7, "R11");
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule